// File: doc/BRIEF.md
# Fixed-Line Nested Interrupt Controller

This block is a reduced interrupt controller for a small embedded processor board. It sits behind a simple register bus that a PCI slave front end decodes. Four interrupt sources are wired to fixed IRQ numbers: a periodic timer tick, a network adapter and two serial ports. The block captures rising edges on those sources as pending requests. It resolves them against a mask and against the set of interrupts already in service, using a fixed scheme in which a lower IRQ number always wins. It raises a single request line to the CPU when a pending request should interrupt it.

When the CPU pulses acknowledge, the block returns a vector equal to a programmable base plus the IRQ number. In the same cycle it moves that request into the in-service set. Service ends only when software writes a specific end-of-interrupt command that names the IRQ. There is no cascading, no rotating priority, no automatic or non-specific end of service, no special mask mode and no polling. Software can read back the mask, the vector base, the pending set and the in-service set.

Top module: `fixed_irq_ctrl`

## Requirements
- R1: The sources map to fixed IRQ numbers: `src_tick` to IRQ 0, `src_net` to IRQ 5, `src_ser0` to IRQ 4 and `src_ser1` to IRQ 3. Bit n of the pending and in-service registers belongs to IRQ n. Bits 1, 2, 6 and 7 always read 0.
- R2: A rising edge on a source sets its pending bit at the next clock edge. The bit stays set until that IRQ is acknowledged. A source held high after acknowledge does not set the bit again.
- R3: A set bit n in the mask register keeps IRQ n out of priority resolution, so it cannot raise `cpu_irq`. Its pending bit is still captured while it is masked.
- R4: `cpu_irq` is high exactly when some unmasked pending IRQ has a lower number than every in-service IRQ, or when nothing is in service. Lower numbers have higher priority.
- R5: When `cpu_ack` is high while `cpu_irq` is high, `ack_vector` equals the vector base plus the number of the highest-priority unmasked pending IRQ, taken modulo 256. At that clock edge the IRQ's pending bit clears and its in-service bit sets.
- R6: When `cpu_ack` is high while `cpu_irq` is low, `ack_vector` equals the base plus 7, and neither the pending nor the in-service register changes.
- R7: Writing value n to address 2 clears in-service bit n. The write has no effect if n is above 7, if n is not a wired IRQ, or if IRQ n is not in service.
- R8: Register map: address 0 is the mask (read/write, reset 0x00), address 1 is the vector base (read/write, reset 0x20), address 2 reads the pending register, and address 3 reads the in-service register. Reads are combinational from `bus_addr`.
- R9: Nesting: while a lower-priority IRQ is in service, a higher-numbered request waits. A lower-numbered request still raises `cpu_irq`. Once the blocking IRQ's end-of-interrupt command is written, the waiting request raises `cpu_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 1 | Periodic timer source (IRQ 0) |
| src_net | input | 1 | Network adapter source (IRQ 5) |
| src_ser0 | input | 1 | First serial port source (IRQ 4) |
| src_ser1 | input | 1 | Second serial port source (IRQ 3) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| cpu_ack | input | 1 | Interrupt acknowledge pulse from the CPU |
| ack_vector | output | 8 | Vector returned while acknowledge is high |

## Verification
The bench builds the block with the reset vector base set explicitly to 0x20. Later it reprograms the base to 0x40, so both the reset base and a written base appear in the returned vectors. With these values every wired IRQ number shows up as a distinct vector. They also bring several cases within reach: several requests pending at the same time, a spurious acknowledge (base plus 7), an out-of-range end-of-interrupt value that would alias IRQ 0 if its upper bits were ignored, and nesting a timer tick under a serial port in service.

// File: rtl/fic_pkg.sv
package fic_pkg;
    localparam int IRQ_W  = 3;
    localparam int NIRQ   = 1 << IRQ_W;
    localparam int NSRC   = 4;
    localparam int DATA_W = 8;
    localparam logic [IRQ_W-1:0] SPUR_IRQ = IRQ_W'(NIRQ - 1);

    // source index: 0 tick, 1 net, 2 ser0, 3 ser1
    localparam logic [IRQ_W-1:0] SRC_IRQ [NSRC] = '{3'd0, 3'd5, 3'd4, 3'd3};

    typedef enum logic [1:0] {
        ADDR_MASK = 2'd0,
        ADDR_BASE = 2'd1,
        ADDR_REQ  = 2'd2,
        ADDR_SVC  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [NIRQ-1:0]   mask;
        logic [DATA_W-1:0] base;
        logic [NIRQ-1:0]   req;
        logic [NIRQ-1:0]   svc;
    } ctrl_state_t;

    function automatic logic [NIRQ-1:0] wired_lines();
        logic [NIRQ-1:0] r;
        r = '0;
        for (int i = 0; i < NSRC; i++) r[SRC_IRQ[i]] = 1'b1;
        return r;
    endfunction

    localparam logic [NIRQ-1:0] WIRED = wired_lines();
endpackage

// File: rtl/fic_edge_detect.sv
module fic_edge_detect #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    always_comb prev_d = lvl;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_rise
        assign rise[g] = lvl[g] & ~prev_q[g];
    end
endmodule

// File: rtl/fic_prio_pick.sv
module fic_prio_pick #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic         found,
    output logic [W-1:0] idx
);
    // lowest set index wins
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/fixed_irq_ctrl.sv
module fixed_irq_ctrl
    import fic_pkg::*;
#(
    parameter logic [DATA_W-1:0] BASE_RESET = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_tick,
    input  logic              src_net,
    input  logic              src_ser0,
    input  logic              src_ser1,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cpu_irq,
    input  logic              cpu_ack,
    output logic [DATA_W-1:0] ack_vector
);
    ctrl_state_t st_d, st_q;

    logic [NSRC-1:0]  src_vec, src_rise;
    logic [NIRQ-1:0]  rise_irq, pend;
    logic             pend_found, svc_found, take_ack, eoi_ok;
    logic [IRQ_W-1:0] pend_idx, svc_idx, eoi_idx;

    assign src_vec = {src_ser1, src_ser0, src_net, src_tick};

    fic_edge_detect #(.N(NSRC)) edge_i (
        .clk(clk), .rst_n(rst_n), .lvl(src_vec), .rise(src_rise)
    );

    always_comb begin
        rise_irq = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (src_rise[i]) rise_irq[SRC_IRQ[i]] = 1'b1;
        end
    end

    assign pend = st_q.req & ~st_q.mask;

    fic_prio_pick #(.N(NIRQ)) pend_pick_i (
        .vec(pend), .found(pend_found), .idx(pend_idx)
    );
    fic_prio_pick #(.N(NIRQ)) svc_pick_i (
        .vec(st_q.svc), .found(svc_found), .idx(svc_idx)
    );

    assign cpu_irq    = pend_found && (!svc_found || (pend_idx < svc_idx));
    assign take_ack   = cpu_ack && cpu_irq;
    assign ack_vector = st_q.base + {{(DATA_W-IRQ_W){1'b0}}, (cpu_irq ? pend_idx : SPUR_IRQ)};

    assign eoi_idx = bus_wdata[IRQ_W-1:0];
    assign eoi_ok  = (bus_wdata[DATA_W-1:IRQ_W] == '0) && WIRED[eoi_idx];

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            unique case (reg_addr_e'(bus_addr))
                ADDR_MASK: st_d.mask = bus_wdata;
                ADDR_BASE: st_d.base = bus_wdata;
                ADDR_REQ:  if (eoi_ok) st_d.svc[eoi_idx] = 1'b0;
                default:   ;
            endcase
        end
        if (take_ack) begin
            st_d.req[pend_idx] = 1'b0;
            st_d.svc[pend_idx] = 1'b1;
        end
        st_d.req = st_d.req | (rise_irq & WIRED);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask <= '0;
            st_q.base <= BASE_RESET;
            st_q.req  <= '0;
            st_q.svc  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (reg_addr_e'(bus_addr))
            ADDR_MASK: bus_rdata = st_q.mask;
            ADDR_BASE: bus_rdata = st_q.base;
            ADDR_REQ:  bus_rdata = st_q.req;
            default:   bus_rdata = st_q.svc;
        endcase
    end

    // R1: unwired lines never hold state
    a_r1_unwired_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.req | st_q.svc) & ~WIRED) == '0);

    // R2: a pending bit falls only through an acknowledge
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ack |=> (($past(st_q.req) & ~st_q.req) == '0));

    // R5: a granted acknowledge adds exactly one in-service bit
    a_r5_ack_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        take_ack |=> ($countones(st_q.svc & ~$past(st_q.svc)) == 1));

    // R5: in-service bits never appear without a granted acknowledge
    a_r5_no_svc_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !take_ack |=> ((st_q.svc & ~$past(st_q.svc)) == '0));

    // R6: spurious acknowledge leaves the pending set unchanged when no edge arrives
    a_r6_spurious_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && !cpu_irq && (src_rise == '0)) |=> (st_q.req == $past(st_q.req)));
endmodule

// File: tb/fixed_irq_ctrl_tb_top.sv
module fixed_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_tick = 0, src_net = 0, src_ser0 = 0, src_ser1 = 0;
    logic       bus_wr = 0;
    logic [1:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       cpu_irq;
    logic       cpu_ack = 0;
    logic [7:0] ack_vector;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fixed_irq_ctrl #(.BASE_RESET(8'h20)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .src_tick(src_tick), .src_net(src_net), .src_ser0(src_ser0), .src_ser1(src_ser1),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_irq(cpu_irq), .cpu_ack(cpu_ack), .ack_vector(ack_vector)
    );

    // monitor: compares returned vectors against the scoreboard queue
    always @(posedge clk) begin
        if (rst_n && cpu_ack) begin
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected acknowledge: actual %02h expected none", ack_vector);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (ack_vector !== e) begin
                    n_bad++;
                    $display("FAIL %s vector: actual %02h expected %02h", t, ack_vector, e);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic rd(input string tag, input logic [1:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic ack(input string tag, input logic [7:0] exp);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        cpu_ack = 1'b1;
        step();
        cpu_ack = 1'b0;
    endtask

    task automatic irq_is(input string tag, input logic exp);
        check(tag, {7'd0, cpu_irq}, {7'd0, exp});
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog expired: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R8 reset state
        rd("R8 mask reset", 2'd0, 8'h00);
        rd("R8 base reset", 2'd1, 8'h20);
        rd("R8 req reset", 2'd2, 8'h00);
        rd("R8 svc reset", 2'd3, 8'h00);
        irq_is("R4 idle irq", 1'b0);

        // R1/R2 network source to IRQ 5
        src_net = 1; step(); src_net = 0; step();
        rd("R1 net maps to bit 5", 2'd2, 8'h20);
        irq_is("R4 irq with pending", 1'b1);
        ack("R5 net", 8'h25);
        rd("R5 req cleared", 2'd2, 8'h00);
        rd("R5 svc set", 2'd3, 8'h20);
        irq_is("R5 irq drops after ack", 1'b0);
        wr(2'd2, 8'd5);
        rd("R7 eoi 5", 2'd3, 8'h00);

        // R2 held level latches once
        src_ser0 = 1; step();
        rd("R1 ser0 maps to bit 4", 2'd2, 8'h10);
        ack("R5 ser0", 8'h24);
        step(); step();
        rd("R2 held level no relatch", 2'd2, 8'h00);
        src_ser0 = 0; step();
        wr(2'd2, 8'd4);

        // R3 mask
        wr(2'd0, 8'h08);
        src_ser1 = 1; step(); src_ser1 = 0; step();
        rd("R3 masked still latched", 2'd2, 8'h08);
        irq_is("R3 masked no irq", 1'b0);
        wr(2'd0, 8'h00);
        irq_is("R3 unmask raises irq", 1'b1);
        ack("R1 ser1", 8'h23);
        rd("R5 svc ser1", 2'd3, 8'h08);

        // R9 nesting
        src_net = 1; step(); src_net = 0; step();
        irq_is("R9 lower priority waits", 1'b0);
        src_tick = 1; step(); src_tick = 0; step();
        rd("R1 tick maps to bit 0", 2'd2, 8'h21);
        irq_is("R9 higher priority interrupts", 1'b1);
        ack("R9 tick nested", 8'h20);
        rd("R9 svc nested", 2'd3, 8'h09);
        irq_is("R9 irq after nested ack", 1'b0);

        // R7 ineffective EOIs
        wr(2'd2, 8'd5);
        rd("R7 eoi not in service", 2'd3, 8'h09);
        wr(2'd2, 8'd1);
        rd("R7 eoi unwired", 2'd3, 8'h09);
        wr(2'd2, 8'd8);
        rd("R7 eoi out of range", 2'd3, 8'h09);
        wr(2'd2, 8'd0);
        rd("R7 eoi 0", 2'd3, 8'h08);
        irq_is("R9 still blocked by 3", 1'b0);
        wr(2'd2, 8'd3);
        rd("R7 eoi 3", 2'd3, 8'h00);
        irq_is("R9 waiting request released", 1'b1);

        // R6 spurious
        wr(2'd0, 8'h20);
        irq_is("R3 masked pending no irq", 1'b0);
        ack("R6 spurious", 8'h27);
        rd("R6 svc unchanged", 2'd3, 8'h00);
        rd("R6 req unchanged", 2'd2, 8'h20);

        // R8 base change
        wr(2'd1, 8'h40);
        wr(2'd0, 8'h00);
        rd("R8 base readback", 2'd1, 8'h40);
        ack("R5 new base", 8'h45);
        wr(2'd2, 8'd5);

        // R4 several pending at once
        src_net = 1; src_ser0 = 1; src_ser1 = 1; step();
        src_net = 0; src_ser0 = 0; src_ser1 = 0; step();
        rd("R2 three pending", 2'd2, 8'h38);
        ack("R4 first pick 3", 8'h43);
        irq_is("R4 4 and 5 wait under 3", 1'b0);
        wr(2'd2, 8'd3);
        ack("R4 second pick 4", 8'h44);
        wr(2'd2, 8'd4);
        ack("R4 third pick 5", 8'h45);
        wr(2'd2, 8'd5);
        rd("R7 all ended", 2'd3, 8'h00);

        step();
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R5 acknowledges missing: actual %0d left expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule